// File: doc/BRIEF.md
# Serially Loaded Shift-Register Lookup Memory

This block is a read-only lookup table of 2^ADDR_W words, each DATA_W bits wide. Its storage is a set of 16-bit shift cells. Each cell has a 4-bit tap select that puts any one of its stored bits on a read output. Every output bit has its own column of cells, chained end to end. The low four address bits pick the tap inside a cell. The remaining address bits pick which cell of the column drives the output. Reads are combinational from the address.

Contents cannot be written at a random address. They are loaded by shifting one bit per clock while the load enable is high. The columns form one serial chain, and the end of that chain comes out of the block. The enable also comes out, delayed by one clock, so several of these memories can be placed in a daisy chain and filled from a single bit stream. The design supports ADDR_W of 4 or more.

Top module: `shift_lut_mem`

## Requirements
- R1: With `load_en` low, `rd_data[c]` equals the stored bit of column c at address `rd_addr`, combinationally and in the same cycle. `rd_addr[3:0]` selects the bit inside a 16-bit cell, and `rd_addr[ADDR_W-1:4]` selects the cell.
- R2: Hold `load_en` high for L = DATA_W*2^ADDR_W clocks. The bit on `ser_in` at the first of those edges lands in column DATA_W-1 at the top address. Later bits fill the lower addresses of that column in descending order, then column DATA_W-2 from its top address down, and so on. The last bit lands in column 0 at address 0.
- R3: While `load_en` is low, the stored contents and `ser_out` do not change, and `ser_in` is ignored.
- R4: Each clock with `load_en` high moves every stored bit one address up within its column. The bit at the top address of column c moves to address 0 of column c+1, and `ser_in` enters column 0 at address 0.
- R5: `ser_out` is the bit held at the top address of column DATA_W-1. During continuous loading it therefore repeats `ser_in` L clocks later, and it shifts out the old contents in the order they were loaded.
- R6: `load_en_out` equals `load_en` delayed by exactly one clock.
- R7: While `rst_n` is low, `load_en_out` is 0. Reset is applied asynchronously and released synchronously to `clk`. Reset does not clear the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial load data |
| load_en | input | 1 | Serial load enable; shifts the chain by one bit per clock |
| ser_out | output | 1 | End of the serial chain, for the next memory |
| load_en_out | output | 1 | Load enable delayed by one clock, for the next memory |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read word |

## Verification
The memory is filled in turn with all zeros, all ones, a word equal to its address, and a scrambled pattern, and every address is read back after each load. The all-zero and all-one patterns expose stuck taps. Address-valued words distinguish the cell select from the tap select and catch column swaps. The scrambled pattern catches errors in the load order. While the second pattern loads, every bit leaving `ser_out` is compared with the first pattern's contents in load order. A short three-bit partial shift then checks that bits carry across cell and column boundaries, and a stretch of toggling `ser_in` with the enable low shows that idle input leaves the contents unchanged.

// File: rtl/slm_pkg.sv
`timescale 1ns/1ps
package slm_pkg;
  localparam int CELL_BITS = 16;
  localparam int TAP_W     = 4;

  function automatic int cells_per_column(input int addr_w);
    return 1 << (addr_w - TAP_W);
  endfunction
endpackage

// File: rtl/slm_shift_cell.sv
`timescale 1ns/1ps
module slm_shift_cell
  import slm_pkg::*;
(
  input  logic             clk,
  input  logic             en,
  input  logic             din,
  input  logic [TAP_W-1:0] tap,
  output logic             tap_q,
  output logic             casc_q
);
  logic [CELL_BITS-1:0] bits_q;
  logic [CELL_BITS-1:0] bits_d;

  // next state: shift toward bit 15 under clock enable
  always_comb begin
    bits_d = bits_q;
    if (en) bits_d = {bits_q[CELL_BITS-2:0], din};
  end

  // storage carries no reset: contents come only from loading
  always_ff @(posedge clk) begin
    bits_q <= bits_d;
  end

  assign tap_q  = bits_q[tap];
  assign casc_q = bits_q[CELL_BITS-1];
endmodule

// File: rtl/slm_column.sv
`timescale 1ns/1ps
module slm_column
  import slm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  output logic              rbit,
  output logic              dout
);
  localparam int CELLS = cells_per_column(ADDR_W);
  localparam int SEL_W = ADDR_W - TAP_W;

  logic [CELLS:0]   link;
  logic [CELLS-1:0] taps;

  assign link[0] = din;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    slm_shift_cell u_cell (
      .clk    (clk),
      .en     (en),
      .din    (link[k]),
      .tap    (addr[TAP_W-1:0]),
      .tap_q  (taps[k]),
      .casc_q (link[k+1])
    );
  end

  if (SEL_W == 0) begin : g_one
    assign rbit = taps[0];
  end else begin : g_mux
    assign rbit = taps[addr[ADDR_W-1:TAP_W]];
  end

  assign dout = link[CELLS];
endmodule

// File: rtl/slm_rst_sync.sv
`timescale 1ns/1ps
module slm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/shift_lut_mem.sv
`timescale 1ns/1ps
module shift_lut_mem
  import slm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              load_en,
  output logic              ser_out,
  output logic              load_en_out,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic          rst_q;
  logic [DATA_W:0] chain;
  logic          en_out_q;
  logic          en_out_d;

  slm_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // column c is fed by column c-1; sdi enters column 0
  assign chain[0] = ser_in;

  for (genvar c = 0; c < DATA_W; c++) begin : g_col
    slm_column #(.ADDR_W(ADDR_W)) u_col (
      .clk  (clk),
      .en   (load_en),
      .din  (chain[c]),
      .addr (rd_addr),
      .rbit (rd_data[c]),
      .dout (chain[c+1])
    );
  end

  assign ser_out = chain[DATA_W];

  // enable pass-through register
  always_comb en_out_d = load_en;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) en_out_q <= 1'b0;
    else        en_out_q <= en_out_d;
  end

  assign load_en_out = en_out_q;

  // R6: enable forwarded one clock later
  a_r6_enable_rise: assert property (@(posedge clk) disable iff (!rst_q)
    load_en |=> load_en_out) else $error("a_r6_enable_rise");
  a_r6_enable_fall: assert property (@(posedge clk) disable iff (!rst_q)
    !load_en |=> !load_en_out) else $error("a_r6_enable_fall");
  // R3: contents hold while not loading
  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (!$past(load_en) && $stable(rd_addr)) |-> $stable(rd_data)) else $error("a_r3_read_hold");
  // R5 / R3: chain end moves only under the load enable
  a_r5_sdo_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !load_en |=> $stable(ser_out)) else $error("a_r5_sdo_hold");
  // R7: forwarded enable low while reset is held
  always_comb begin
    if (!rst_n) a_r7_reset_low: assert (load_en_out == 1'b0) else $error("a_r7_reset_low");
  end
endmodule

// File: tb/sim_shift_lut_mem.sv
`timescale 1ns/1ps
module sim_shift_lut_mem;
  localparam int AW = 6;
  localparam int DW = 4;
  localparam int D  = 1 << AW;
  localparam int L  = DW * D;

  logic          clk = 1'b0;
  logic          rst_n, sdi, sei, sdo, seo;
  logic [AW-1:0] addr;
  logic [DW-1:0] rdata;

  always #10 clk = ~clk;

  shift_lut_mem #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(sdi), .load_en(sei),
    .ser_out(sdo), .load_en_out(seo), .rd_addr(addr), .rd_data(rdata)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] e; string tag; } item_t;
  item_t q[$];
  logic [DW-1:0] model [D];
  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare the read word against the scoreboard
  always @(posedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      check(rdata === it.e, it.tag, $sformatf("read addr %0d", it.a), int'(rdata), int'(it.e));
    end
  end

  function automatic logic [DW-1:0] pat(input int p, input int a);
    case (p)
      0:       return '0;
      1:       return '1;
      2:       return DW'(a);
      default: return DW'((a * 29 + 7) ^ (a >> 3));
    endcase
  endfunction

  function automatic logic gbit(input logic [DW-1:0] m [D], input int g);
    return m[g % D][g / D];
  endfunction

  task automatic read_all(input string tag);
    for (int a = 0; a < D; a++) begin
      @(negedge clk);
      addr = AW'(a);
      q.push_back('{AW'(a), model[a], tag});
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // R2 load order: global position g = c*D + a, first bit goes to g = L-1
  task automatic load(input int p, input bit chk_sdo);
    logic [DW-1:0] nw [D];
    for (int a = 0; a < D; a++) nw[a] = pat(p, a);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      if (chk_sdo) check(sdo === gbit(model, L-1-k), "R5", $sformatf("ser_out after %0d shifts", k),
                         int'(sdo), int'(gbit(model, L-1-k)));
      if (k == 1) check(seo === 1'b1, "R6", "load_en_out one clock after start", int'(seo), 1);
      sei = 1'b1;
      sdi = gbit(nw, L-1-k);
    end
    @(negedge clk);
    sei = 1'b0;
    model = nw;
    check(sdo === gbit(model, L-1), "R5", "ser_out after full load", int'(sdo), int'(gbit(model, L-1)));
    @(negedge clk);
    check(seo === 1'b0, "R6", "load_en_out one clock after stop", int'(seo), 0);
  endtask

  // R4: partial shift, model moves every bit one global position up
  task automatic shift_in(input logic b);
    logic [DW-1:0] nw [D];
    @(negedge clk);
    sei = 1'b1;
    sdi = b;
    for (int g = L-1; g > 0; g--) nw[g % D][g / D] = gbit(model, g-1);
    nw[0][0] = b;
    @(negedge clk);
    sei = 1'b0;
    model = nw;
  endtask

  initial begin
    logic held;
    rst_n = 1'b0; sei = 1'b0; sdi = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    check(seo === 1'b0, "R7", "load_en_out in reset", int'(seo), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(seo === 1'b0, "R7", "load_en_out after reset release", int'(seo), 0);

    load(3, 1'b0); read_all("R2");
    load(2, 1'b1); read_all("R1");
    load(0, 1'b1); read_all("R1");
    load(1, 1'b1); read_all("R1");
    load(3, 1'b1); read_all("R2");

    // R3: sdi toggles with the enable low
    held = sdo;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sdi = ~sdi;
      addr = AW'(i * 5);
    end
    @(negedge clk);
    check(sdo === held, "R3", "ser_out while idle", int'(sdo), int'(held));
    read_all("R3");

    shift_in(1'b1); shift_in(1'b0); shift_in(1'b1);
    read_all("R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule